// File: doc/BRIEF.md
# Masked RTC Alarm and Interrupt Unit

This block sits beside a real-time clock counter. It watches the counter's packed BCD time word and date word, and compares them against two programmable alarm words. Every alarm field has its own enable bit, so software can match on any subset of seconds, minutes, hours, month and day of month. The alarm words have no year field, so the year and the century never affect a match. A match sets the alarm bit of a small event status register.

The same register also collects the counter's other events: the update acknowledge, the second tick, the time event and the calendar event. Each status bit stays set until software writes a one to it through a clear strobe. An interrupt mask can only be changed through separate set and clear strobes, and it can always be read back. One interrupt line goes high while any status bit is set under a set mask bit.

A combinational entry checker reports out-of-range or non-BCD values in the live time and date words and in the enabled fields of both alarm words.

Top module: `rtc_alarm_irq_unit`

## Requirements
- R1: The time alarm word holds seconds in bits 6:0, minutes in 14:8 and hours in 21:16, all BCD. Bit 7 enables the seconds compare, bit 15 the minutes compare and bit 23 the hours compare. It is written from `wdata_i` on `talm_we_i` and reads back on `talm_o` one cycle later, with every other bit read as zero (read mask 0x00BFFFFF).
- R2: The date alarm word holds the month in bits 20:16 and the day of month in bits 29:24. Bit 23 enables the month compare and bit 31 the day-of-month compare; every other bit reads as zero (read mask 0xBF9F0000). The year (bits 15:8) and century (bits 6:0) of `now_date_i` never affect a match.
- R3: Status bit 1 (alarm) is set at the clock edge where at least one field is enabled and every enabled field equals the live time and date. It is set only when the match begins, so a match that lasts many cycles sets it once.
- R4: With all five enable bits clear, status bit 1 is never set.
- R5: Event pulses set their status bits: `upd_ack_i` sets bit 0, `sec_evt_i` bit 2, `time_evt_i` bit 3 and `cal_evt_i` bit 4. A set bit holds until it is cleared.
- R6: With `stat_clr_we_i` high, each status bit whose `wdata_i` bit is one is cleared at the edge. Zero bits leave the status unchanged.
- R7: If a status bit is set and cleared in the same cycle, it ends up set.
- R8: With `irq_en_we_i` high, each one in `wdata_i` sets that mask bit. With `irq_dis_we_i` high, each one clears it. If both strobes touch the same bit, the set wins. `mask_o` shows the mask one cycle after the write.
- R9: `irq_o` is high in exactly the cycles where some status bit and the same mask bit are both one.
- R10: `bad_entry_o` flags values combinationally. Bit 0 is a bad time word (seconds or minutes above 59, hours above 23, or a units digit above 9). Bit 1 is a bad date word (month not 1..12, day of month not 1..31, weekday in bits 23:21 not 1..7). Bit 2 is a bad enabled field in the time alarm. Bit 3 is a bad enabled month or day-of-month field in the date alarm.
- R11: After reset the alarm words, status and mask are zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| now_time_i | input | 32 | Live BCD time word from the counter |
| now_date_i | input | 32 | Live BCD date word from the counter |
| upd_ack_i | input | 1 | Update acknowledge pulse |
| sec_evt_i | input | 1 | Second tick pulse |
| time_evt_i | input | 1 | Time event pulse |
| cal_evt_i | input | 1 | Calendar event pulse |
| talm_we_i | input | 1 | Write strobe for the time alarm word |
| calm_we_i | input | 1 | Write strobe for the date alarm word |
| stat_clr_we_i | input | 1 | Write-one-to-clear strobe for the status |
| irq_en_we_i | input | 1 | Mask set strobe |
| irq_dis_we_i | input | 1 | Mask clear strobe |
| wdata_i | input | 32 | Write data shared by all strobes |
| talm_o | output | 32 | Time alarm word readback |
| calm_o | output | 32 | Date alarm word readback |
| status_o | output | 5 | Event status |
| mask_o | output | 5 | Interrupt mask |
| irq_o | output | 1 | Interrupt line |
| bad_entry_o | output | 4 | Invalid-entry flags |

## Verification
The alarm words, the status and the mask are registered. Their result is due at the first rising edge after a strobe or event is applied. This includes the alarm bit, which is due at the edge where the matching time is first presented. `irq_o` and `bad_entry_o` are combinational from those registers and the live inputs, so they are due in the same cycle. The bench drives every input on the falling edge. It samples registered results on the next falling edge, and samples combinational results a short delay after the inputs change. For every alarm vector, a mismatching time is presented and the status is cleared first, so each match is a fresh rising match.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;

   localparam int WORD_W   = 32;
   localparam int EVT_MIN  = 5;
   localparam int FLD_N    = 5;
   localparam int ENTRY_W  = 4;

   // status / mask bit positions (write data is decoded by these)
   localparam int EV_UPD = 0;
   localparam int EV_ALM = 1;
   localparam int EV_SEC = 2;
   localparam int EV_TIM = 3;
   localparam int EV_CAL = 4;

   // readable bits of the alarm words
   localparam logic [WORD_W-1:0] TALM_KEEP = 32'h00BF_FFFF;
   localparam logic [WORD_W-1:0] CALM_KEEP = 32'hBF9F_0000;

   // compared fields: sec, min, hour, month, day of month
   localparam int FLD_LSB [FLD_N] = '{0, 8, 16, 16, 24};
   localparam int FLD_W   [FLD_N] = '{7, 7, 6, 5, 6};
   localparam int FLD_EN  [FLD_N] = '{7, 15, 23, 23, 31};
   localparam bit FLD_CAL [FLD_N] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

   // entry-check flag positions
   localparam int BAD_TIME = 0;
   localparam int BAD_DATE = 1;
   localparam int BAD_TALM = 2;
   localparam int BAD_CALM = 3;

   function automatic logic bcd_ok(input logic [7:0] v,
                                   input logic [7:0] lo,
                                   input logic [7:0] hi);
      return (v[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
   endfunction

endpackage

// File: rtl/rtc_alm_cmp.sv
module rtc_alm_cmp
   import rtc_alm_pkg::*;
#(
   parameter int DATA_W = WORD_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] talm_i,
   input  logic [DATA_W-1:0] calm_i,
   input  logic [DATA_W-1:0] now_time_i,
   input  logic [DATA_W-1:0] now_date_i,
   output logic              hit_o
);

   logic [FLD_N-1:0] fld_en;
   logic [FLD_N-1:0] fld_eq;
   logic             match;
   logic             match_q;

   for (genvar g = 0; g < FLD_N; g++) begin : g_fld
      localparam int LSB = FLD_LSB[g];
      localparam int EN  = FLD_EN[g];
      localparam logic [DATA_W-1:0] MSK = (DATA_W'(1) << FLD_W[g]) - DATA_W'(1);
      logic [DATA_W-1:0] alm_f;
      logic [DATA_W-1:0] now_f;
      if (FLD_CAL[g]) begin : g_cal
         assign alm_f     = (calm_i >> LSB) & MSK;
         assign now_f     = (now_date_i >> LSB) & MSK;
         assign fld_en[g] = calm_i[EN];
      end else begin : g_tim
         assign alm_f     = (talm_i >> LSB) & MSK;
         assign now_f     = (now_time_i >> LSB) & MSK;
         assign fld_en[g] = talm_i[EN];
      end
      assign fld_eq[g] = (alm_f == now_f);
   end

   assign match = (|fld_en) && (&(fld_eq | ~fld_en));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) match_q <= 1'b0;
      else         match_q <= match;
   end

   assign hit_o = match & ~match_q;

endmodule

// File: rtl/rtc_evt_status.sv
module rtc_evt_status #(
   parameter int NUM_EVT = 5
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_EVT-1:0] set_i,
   input  logic               clr_we_i,
   input  logic [NUM_EVT-1:0] clr_data_i,
   output logic [NUM_EVT-1:0] status_o
);

   for (genvar k = 0; k < NUM_EVT; k++) begin : g_bit
      logic st_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                       st_q <= 1'b0;
         else if (set_i[k])                 st_q <= 1'b1;
         else if (clr_we_i && clr_data_i[k]) st_q <= 1'b0;
      end
      assign status_o[k] = st_q;
   end

endmodule

// File: rtl/rtc_irq_mask.sv
module rtc_irq_mask #(
   parameter int NUM_EVT = 5
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_we_i,
   input  logic               dis_we_i,
   input  logic [NUM_EVT-1:0] data_i,
   input  logic [NUM_EVT-1:0] status_i,
   output logic [NUM_EVT-1:0] mask_o,
   output logic               irq_o
);

   for (genvar k = 0; k < NUM_EVT; k++) begin : g_bit
      logic m_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                   m_q <= 1'b0;
         else if (en_we_i && data_i[k])  m_q <= 1'b1;
         else if (dis_we_i && data_i[k]) m_q <= 1'b0;
      end
      assign mask_o[k] = m_q;
   end

   assign irq_o = |(status_i & mask_o);

endmodule

// File: rtl/rtc_entry_chk.sv
module rtc_entry_chk
   import rtc_alm_pkg::*;
(
   input  logic [WORD_W-1:0]  now_time_i,
   input  logic [WORD_W-1:0]  now_date_i,
   input  logic [WORD_W-1:0]  talm_i,
   input  logic [WORD_W-1:0]  calm_i,
   output logic [ENTRY_W-1:0] bad_o
);

   logic unused_bits;
   assign unused_bits = ^{now_time_i[31:22], now_time_i[15], now_time_i[7],
                          now_date_i[31:30], now_date_i[15:0],
                          talm_i[31:24], talm_i[22], calm_i[30],
                          calm_i[22:21], calm_i[15:0]};

   function automatic logic time_ok(input logic [WORD_W-1:0] w,
                                    input logic [2:0] en);
      logic s_ok, m_ok, h_ok;
      s_ok = bcd_ok({1'b0, w[6:0]},   8'h00, 8'h59);
      m_ok = bcd_ok({1'b0, w[14:8]},  8'h00, 8'h59);
      h_ok = bcd_ok({2'b0, w[21:16]}, 8'h00, 8'h23);
      return (s_ok || !en[0]) && (m_ok || !en[1]) && (h_ok || !en[2]);
   endfunction

   function automatic logic date_ok(input logic [WORD_W-1:0] w,
                                    input logic [1:0] en);
      logic mo_ok, dm_ok;
      mo_ok = bcd_ok({3'b0, w[20:16]}, 8'h01, 8'h12);
      dm_ok = bcd_ok({2'b0, w[29:24]}, 8'h01, 8'h31);
      return (mo_ok || !en[0]) && (dm_ok || !en[1]);
   endfunction

   always_comb begin
      bad_o           = '0;
      bad_o[BAD_TIME] = !time_ok(now_time_i, 3'b111);
      bad_o[BAD_DATE] = !date_ok(now_date_i, 2'b11) ||
                        (now_date_i[23:21] == 3'd0);
      bad_o[BAD_TALM] = !time_ok(talm_i, {talm_i[23], talm_i[15], talm_i[7]});
      bad_o[BAD_CALM] = !date_ok(calm_i, {calm_i[31], calm_i[23]});
   end

endmodule

// File: rtl/rtc_alarm_irq_unit.sv
module rtc_alarm_irq_unit
   import rtc_alm_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NUM_EVT = 5
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [DATA_W-1:0]  now_time_i,
   input  logic [DATA_W-1:0]  now_date_i,
   input  logic               upd_ack_i,
   input  logic               sec_evt_i,
   input  logic               time_evt_i,
   input  logic               cal_evt_i,
   input  logic               talm_we_i,
   input  logic               calm_we_i,
   input  logic               stat_clr_we_i,
   input  logic               irq_en_we_i,
   input  logic               irq_dis_we_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  talm_o,
   output logic [DATA_W-1:0]  calm_o,
   output logic [NUM_EVT-1:0] status_o,
   output logic [NUM_EVT-1:0] mask_o,
   output logic               irq_o,
   output logic [ENTRY_W-1:0] bad_entry_o
);

   if (DATA_W != WORD_W) begin : g_bad_width
      $error("rtc_alarm_irq_unit: DATA_W must equal the packed word width");
   end
   if (NUM_EVT < EVT_MIN || NUM_EVT > DATA_W) begin : g_bad_evt
      $error("rtc_alarm_irq_unit: NUM_EVT out of range");
   end

   logic [DATA_W-1:0]  talm_q;
   logic [DATA_W-1:0]  calm_q;
   logic               alm_hit;
   logic [NUM_EVT-1:0] evt_set;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         talm_q <= '0;
         calm_q <= '0;
      end else begin
         if (talm_we_i) talm_q <= wdata_i & TALM_KEEP;
         if (calm_we_i) calm_q <= wdata_i & CALM_KEEP;
      end
   end

   rtc_alm_cmp #(.DATA_W(DATA_W)) cmp_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .talm_i     (talm_q),
      .calm_i     (calm_q),
      .now_time_i (now_time_i),
      .now_date_i (now_date_i),
      .hit_o      (alm_hit)
   );

   always_comb begin
      evt_set         = '0;
      evt_set[EV_UPD] = upd_ack_i;
      evt_set[EV_ALM] = alm_hit;
      evt_set[EV_SEC] = sec_evt_i;
      evt_set[EV_TIM] = time_evt_i;
      evt_set[EV_CAL] = cal_evt_i;
   end

   rtc_evt_status #(.NUM_EVT(NUM_EVT)) stat_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (evt_set),
      .clr_we_i   (stat_clr_we_i),
      .clr_data_i (wdata_i[NUM_EVT-1:0]),
      .status_o   (status_o)
   );

   rtc_irq_mask #(.NUM_EVT(NUM_EVT)) mask_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_we_i  (irq_en_we_i),
      .dis_we_i (irq_dis_we_i),
      .data_i   (wdata_i[NUM_EVT-1:0]),
      .status_i (status_o),
      .mask_o   (mask_o),
      .irq_o    (irq_o)
   );

   rtc_entry_chk chk_entry_i (
      .now_time_i (now_time_i),
      .now_date_i (now_date_i),
      .talm_i     (talm_q),
      .calm_i     (calm_q),
      .bad_o      (bad_entry_o)
   );

   assign talm_o = talm_q;
   assign calm_o = calm_q;

endmodule

// File: rtl/rtc_alarm_irq_unit_chk.sv
module rtc_alarm_irq_unit_chk #(
   parameter int DATA_W  = 32,
   parameter int NUM_EVT = 5
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               upd_ack_i,
   input logic               sec_evt_i,
   input logic               talm_we_i,
   input logic               calm_we_i,
   input logic               stat_clr_we_i,
   input logic               irq_en_we_i,
   input logic               irq_dis_we_i,
   input logic [DATA_W-1:0]  wdata_i,
   input logic [DATA_W-1:0]  talm_o,
   input logic [DATA_W-1:0]  calm_o,
   input logic [NUM_EVT-1:0] status_o,
   input logic [NUM_EVT-1:0] mask_o,
   input logic               irq_o
);

   logic unused_chk;
   assign unused_chk = ^{wdata_i[DATA_W-1:NUM_EVT]};

   // R6
   status_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_clr_we_i && wdata_i[0] && !upd_ack_i) |=> !status_o[0]);

   // R7
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sec_evt_i |=> status_o[2]);

   // R8
   mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_en_we_i |=> ((mask_o & $past(wdata_i[NUM_EVT-1:0])) == $past(wdata_i[NUM_EVT-1:0])));

   // R8
   mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_dis_we_i && !irq_en_we_i) |=> ((mask_o & $past(wdata_i[NUM_EVT-1:0])) == '0));

   // R4
   no_enable_no_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!talm_o[7] && !talm_o[15] && !talm_o[23] && !calm_o[23] && !calm_o[31] &&
       !status_o[1] && !talm_we_i && !calm_we_i) |=> !status_o[1]);

   // R9
   irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mask_o == '0) || (status_o == '0)) |-> !irq_o);

endmodule

bind rtc_alarm_irq_unit rtc_alarm_irq_unit_chk #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) sva_i (.*);

// File: tb/rtc_alarm_irq_unit_tb_top.sv
module rtc_alarm_irq_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 10;
   localparam logic [31:0] IDLE_T = 32'h003F7F7F;
   localparam logic [31:0] IDLE_D = 32'h3F1F0000;

   // {talm, calm, time, date, expected alarm}
   localparam logic [128:0] VEC [NV] = '{
      {32'h0092B4D6, 32'h95870000, 32'h00123456, 32'h15672420, 1'b1},
      {32'h0092B4D6, 32'h95870000, 32'h00123457, 32'h15672420, 1'b0},
      {32'h000509D6, 32'h00000000, 32'h00224456, 32'h00000000, 1'b1},
      {32'h00000000, 32'h00870000, 32'h00000000, 32'h01670000, 1'b1},
      {32'h00000000, 32'h00870000, 32'h00000000, 32'h01680000, 1'b0},
      {32'h00000000, 32'h95000000, 32'h00000000, 32'h15010000, 1'b1},
      {32'h00123456, 32'h15070000, 32'h00123456, 32'h15672420, 1'b0},
      {32'h0092B4D6, 32'h95870000, 32'h00123456, 32'h15679919, 1'b1},
      {32'h0005B4D6, 32'h00000000, 32'h00233456, 32'h00000000, 1'b1},
      {32'h00000000, 32'h95870000, 32'h00000000, 32'h16670000, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] now_time = 32'h0, now_date = 32'h01210000;
   logic        upd_ack = 0, sec_evt = 0, time_evt = 0, cal_evt = 0;
   logic        talm_we = 0, calm_we = 0, clr_we = 0, en_we = 0, dis_we = 0;
   logic [31:0] wdata = '0;
   logic [31:0] talm, calm;
   logic [4:0]  status, mask;
   logic        irq;
   logic [3:0]  bad;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_alarm_irq_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n), .now_time_i(now_time), .now_date_i(now_date),
      .upd_ack_i(upd_ack), .sec_evt_i(sec_evt), .time_evt_i(time_evt),
      .cal_evt_i(cal_evt), .talm_we_i(talm_we), .calm_we_i(calm_we),
      .stat_clr_we_i(clr_we), .irq_en_we_i(en_we), .irq_dis_we_i(dis_we),
      .wdata_i(wdata), .talm_o(talm), .calm_o(calm), .status_o(status),
      .mask_o(mask), .irq_o(irq), .bad_entry_o(bad)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one write cycle: strobes high for one clock, results visible on return
   task automatic wr(input logic [31:0] d, input logic t, input logic c,
                     input logic s, input logic e, input logic x);
      wdata = d; talm_we = t; calm_we = c; clr_we = s; en_we = e; dis_we = x;
      @(negedge clk);
      talm_we = 0; calm_we = 0; clr_we = 0; en_we = 0; dis_we = 0; wdata = '0;
   endtask

   task automatic load_alarm(input logic [31:0] ta, input logic [31:0] ca);
      now_time = IDLE_T; now_date = IDLE_D;
      wr(ta, 1, 0, 0, 0, 0);
      wr(ca, 0, 1, 0, 0, 0);
      wr(32'h2, 0, 0, 1, 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 status", {27'h0, status}, 32'h0);
      chk("R11 mask", {27'h0, mask}, 32'h0);
      chk("R11 irq", {31'h0, irq}, 32'h0);
      chk("R11 talm", talm, 32'h0);
      chk("R11 calm", calm, 32'h0);
      chk("R10 reset entries", {28'h0, bad}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R2 R4: vector table
      for (int i = 0; i < NV; i++) begin
         load_alarm(VEC[i][128:97], VEC[i][96:65]);
         now_time = VEC[i][64:33];
         now_date = VEC[i][32:1];
         @(negedge clk);
         chk($sformatf("R3 alarm vector %0d", i), {31'h0, status[1]}, {31'h0, VEC[i][0]});
      end

      // R3 a held match fires once
      load_alarm(32'h0092B4D6, 32'h95870000);
      now_time = 32'h00123456; now_date = 32'h15672420;
      @(negedge clk);
      chk("R3 match sets", {31'h0, status[1]}, 32'h1);
      wr(32'h2, 0, 0, 1, 0, 0);
      chk("R3 cleared during match", {31'h0, status[1]}, 32'h0);
      repeat (3) @(negedge clk);
      chk("R3 held match no refire", {31'h0, status[1]}, 32'h0);
      now_time = IDLE_T;
      @(negedge clk);
      now_time = 32'h00123456;
      @(negedge clk);
      chk("R3 new match refires", {31'h0, status[1]}, 32'h1);

      // R5 R6 R7 events and clear
      now_time = IDLE_T; now_date = IDLE_D;
      wr(32'h1F, 0, 0, 1, 0, 0);
      chk("R6 clear all", {27'h0, status}, 32'h0);
      sec_evt = 1; @(negedge clk); sec_evt = 0;
      chk("R5 second", {27'h0, status}, 32'h04);
      upd_ack = 1; @(negedge clk); upd_ack = 0;
      chk("R5 update ack", {27'h0, status}, 32'h05);
      time_evt = 1; @(negedge clk); time_evt = 0;
      chk("R5 time event", {27'h0, status}, 32'h0D);
      cal_evt = 1; @(negedge clk); cal_evt = 0;
      chk("R5 calendar event", {27'h0, status}, 32'h1D);
      repeat (2) @(negedge clk);
      chk("R5 bits hold", {27'h0, status}, 32'h1D);
      wr(32'h04, 0, 0, 1, 0, 0);
      chk("R6 clear one bit", {27'h0, status}, 32'h19);
      sec_evt = 1;
      wr(32'h04, 0, 0, 1, 0, 0);
      sec_evt = 0;
      chk("R7 set wins over clear", {27'h0, status}, 32'h1D);

      // R8 R9 mask and interrupt
      chk("R9 no mask no irq", {31'h0, irq}, 32'h0);
      wr(32'h06, 0, 0, 0, 1, 0);
      chk("R8 mask set", {27'h0, mask}, 32'h06);
      wr(32'h02, 0, 0, 0, 0, 1);
      chk("R8 mask clear", {27'h0, mask}, 32'h04);
      wr(32'h08, 0, 0, 0, 1, 1);
      chk("R8 set wins", {27'h0, mask}, 32'h0C);
      chk("R9 irq on masked status", {31'h0, irq}, 32'h1);
      wr(32'h0C, 0, 0, 0, 0, 1);
      chk("R9 irq off after mask clear", {31'h0, irq}, 32'h0);
      wr(32'h02, 0, 0, 0, 1, 0);
      chk("R9 mask on idle bit no irq", {31'h0, irq}, 32'h0);
      wr(32'h10, 0, 0, 0, 1, 0);
      chk("R9 irq on calendar", {31'h0, irq}, 32'h1);
      wr(32'h10, 0, 0, 1, 0, 0);
      chk("R9 irq drops on clear", {31'h0, irq}, 32'h0);

      // R1 R2 readback masks
      wr(32'hFFFFFFFF, 1, 1, 0, 0, 0);
      chk("R1 time alarm readback", talm, 32'h00BFFFFF);
      chk("R2 date alarm readback", calm, 32'hBF9F0000);

      // R10 entry checks
      wr(32'h0, 1, 1, 0, 0, 0);
      now_time = 32'h00235959; now_date = 32'h31F20000; #1;
      chk("R10 valid words", {28'h0, bad}, 32'h0);
      now_time = 32'h00240000; #1;
      chk("R10 hour 24", {28'h0, bad}, 32'h1);
      now_time = 32'h00006000; #1;
      chk("R10 minute 60", {28'h0, bad}, 32'h1);
      now_time = 32'h00235959; now_date = 32'h32F20000; #1;
      chk("R10 day 32", {28'h0, bad}, 32'h2);
      now_date = 32'h01010000; #1;
      chk("R10 weekday 0", {28'h0, bad}, 32'h2);
      now_date = 32'h31F20000;
      @(negedge clk);
      wr(32'h000000DA, 1, 0, 0, 0, 0);
      chk("R10 bad enabled alarm second", {28'h0, bad}, 32'h4);
      wr(32'h0000005A, 1, 0, 0, 0, 0);
      chk("R10 disabled field ignored", {28'h0, bad}, 32'h0);
      wr(32'h00800000, 0, 1, 0, 0, 0);
      chk("R10 bad enabled alarm month", {28'h0, bad}, 32'h8);
      wr(32'h00000000, 0, 1, 0, 0, 0);
      chk("R10 date alarm cleared", {28'h0, bad}, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule